// File: doc/BRIEF.md
# Boot-Configurable Memory Remap Decoder

This block decides which physical memory answers a CPU access at the bottom of the address map, and it can exchange the placement of two external memory windows. A single 32-bit control word, reached through a small register bus, holds a 3-bit alias selector and a 2-bit window-swap selector. While reset is held, the alias selector is loaded from two strap pins, so the part comes out of reset already running from the memory the board strapped.

Each CPU address is decoded combinationally against the current control word. The block returns a one-hot region select, the byte offset inside the selected memory, and an error flag when nothing in the map claims the address. Memory controllers sit downstream and use the select and offset directly.

Top module: `remap_ctrl`

## Requirements
- R1: While rst_n is low the alias selector loads from boot_pins ({boot1, boot0}): boot0=0 gives code 000 (main flash, so the pair 1,0 gives 000), {0,1} gives 001 (system flash), {1,1} gives 011 (SRAM); the swap selector loads 00. Strapping never produces code 010 or 100.
- R2: boot_pins are taken only while reset is low; changing them afterwards leaves the control word unchanged.
- R3: A write with bus_en=1, bus_we=1 and bus_addr=0x00 updates bits 2:0 (alias selector) and 11:10 (swap selector) at the next rising clock edge; bus_rdata shows the control word combinationally whenever bus_addr is 0x00.
- R4: Bits 31:12 and 9:3 always read as zero; writes to any other offset, or with bus_en low, change nothing, and other offsets read as zero.
- R5: Alias codes 000 main flash (1 MB), 001 system flash (32 KB), 010 external NOR (first 128 MB only), 011 SRAM (128 KB), 100 SDRAM bank 1 (256 MB): an address below the target's size selects that target with offset equal to the address; above it the alias does not apply.
- R6: Alias codes 101, 110, 111 alias main flash, while the control word still reads back the written code.
- R7: Native windows: main flash at 0x0800_0000 (1 MB), system flash at 0x1FFF_0000 (32 KB), SRAM at 0x2000_0000 (128 KB), offset = address minus base; where the alias window overlaps a native window the alias wins.
- R8: Swap selector 00: top nibble 0x6 selects NOR, 0xC selects SDRAM bank 1, 0xD selects SDRAM bank 2, 0x7 is unmapped; offset is the low 28 address bits.
- R9: Swap selector 01: top nibble 0x6 selects SDRAM bank 1, 0x7 SDRAM bank 2, 0xC NOR, 0xD is unmapped; codes 10 and 11 behave as 00.
- R10: region_sel bits are 0 main flash, 1 system flash, 2 SRAM, 3 NOR, 4 SDRAM bank 1, 5 SDRAM bank 2; a mapped address sets exactly one bit with dec_err low, an unmapped one sets dec_err with region_sel and phys_addr all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_pins | input | 2 | Strap inputs {boot1, boot0} sampled during reset |
| bus_en | input | 1 | Register bus access strobe |
| bus_we | input | 1 | Register bus write qualifier |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data |
| cpu_addr | input | 32 | CPU address to decode |
| region_sel | output | 6 | One-hot target memory select |
| phys_addr | output | 32 | Byte offset inside the selected memory |
| dec_err | output | 1 | Address hits no mapped region |

## Verification
A corrupted control word shows up at once on bus_rdata at offset 0x00 and on the very next decode, because every address is resolved in the same cycle from the stored selectors. A wrong strap capture is visible on the first read after reset release, and a selector that drifts after reset shows as a readback that changed without a write. Decode faults appear as a wrong select bit, a nonzero offset on an error, or a window boundary one byte off, so probes sit on both sides of every window edge.

// File: rtl/remap_pkg.sv
// Shared constants for the remap decoder: field positions, alias codes,
// region indices and the strap-to-alias translation.
package remap_pkg;
    localparam int DATA_W    = 32;
    localparam int BUS_AW    = 8;
    localparam int N_REGIONS = 6;

    // Control word layout
    localparam int ALIAS_LSB = 0;
    localparam int ALIAS_W   = 3;
    localparam int SWAP_LSB  = 10;
    localparam int SWAP_W    = 2;
    localparam logic [DATA_W-1:0] WR_MASK =
        ((32'h1 << ALIAS_W) - 32'h1) << ALIAS_LSB |
        ((32'h1 << SWAP_W) - 32'h1) << SWAP_LSB;

    // Alias selector codes
    localparam logic [2:0] AL_FLASH = 3'b000;
    localparam logic [2:0] AL_SYSFL = 3'b001;
    localparam logic [2:0] AL_NOR   = 3'b010;
    localparam logic [2:0] AL_SRAM  = 3'b011;
    localparam logic [2:0] AL_SDRAM = 3'b100;

    localparam logic [1:0] SW_NONE = 2'b00;
    localparam logic [1:0] SW_SDR  = 2'b01;

    // One-hot region bit positions
    localparam int RG_FLASH = 0;
    localparam int RG_SYSFL = 1;
    localparam int RG_SRAM  = 2;
    localparam int RG_NOR   = 3;
    localparam int RG_SDR1  = 4;
    localparam int RG_SDR2  = 5;

    // Strap pins {boot1, boot0} to alias code; never yields NOR or SDRAM.
    function automatic logic [2:0] strap_alias(input logic [1:0] pins);
        if (!pins[0])          return AL_FLASH;
        else if (!pins[1])     return AL_SYSFL;
        else                   return AL_SRAM;
    endfunction
endpackage

// File: rtl/remap_cfg_reg.sv
// Control word storage. Loads the strap-derived alias code while reset is
// low, accepts single-cycle writes at REG_OFF, and reads back combinationally.
// Assumes rst_n is synchronous to clk and held for at least one edge.
module remap_cfg_reg
    import remap_pkg::*;
#(
    parameter logic [BUS_AW-1:0] REG_OFF = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        boot_pins,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [2:0]        alias_code,
    output logic [1:0]        swap_code
);
    logic [DATA_W-1:0] cfg_q;
    logic              hit_wr;

    assign hit_wr = bus_en && bus_we && (bus_addr == REG_OFF);

    // Purpose: strap capture during reset, masked software update afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= DATA_W'(strap_alias(boot_pins)) << ALIAS_LSB;
        else if (hit_wr)
            cfg_q <= bus_wdata & WR_MASK;
    end

    // Purpose: readback mux, zero for offsets other than the control word.
    always_comb begin
        bus_rdata = (bus_addr == REG_OFF) ? cfg_q : '0;
    end

    assign alias_code = cfg_q[ALIAS_LSB +: ALIAS_W];
    assign swap_code  = cfg_q[SWAP_LSB +: SWAP_W];

    // Strap capture check: first edge after reset sees the strap code.
    logic       chk_armed = 1'b0;
    logic       chk_rst   = 1'b0;
    logic [1:0] chk_boot  = 2'b00;
    always_ff @(posedge clk) begin
        chk_armed <= 1'b1;
        chk_rst   <= !rst_n;
        chk_boot  <= boot_pins;
        if (chk_armed && chk_rst && rst_n) begin
            p_strap_load_r1: assert (alias_code == strap_alias(chk_boot) && swap_code == SW_NONE)
                else $error("strap capture mismatch");
        end
    end

    p_write_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hit_wr |=> (alias_code == $past(bus_wdata[ALIAS_LSB +: ALIAS_W]) &&
                    swap_code  == $past(bus_wdata[SWAP_LSB +: SWAP_W])));

    p_hold_no_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_wr |=> $stable(bus_rdata & ~WR_MASK) && $stable(alias_code) && $stable(swap_code));

    p_reserved_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata & ~WR_MASK) == '0);
endmodule

// File: rtl/remap_addr_dec.sv
// Combinational address decoder. Resolves the alias window at address zero
// first, then the fixed on-chip windows, then the four 256 MB external
// windows chosen by the top nibble and the swap code. Reserved codes fall back
// to main-flash alias and no swap. clk/rst_n feed only the embedded checks.
module remap_addr_dec
    import remap_pkg::*;
#(
    parameter logic [DATA_W-1:0] FLASH_BASE = 32'h0800_0000,
    parameter int                FLASH_LG   = 20,
    parameter logic [DATA_W-1:0] SYSFL_BASE = 32'h1FFF_0000,
    parameter int                SYSFL_LG   = 15,
    parameter logic [DATA_W-1:0] SRAM_BASE  = 32'h2000_0000,
    parameter int                SRAM_LG    = 17,
    parameter int                NOR_AL_LG  = 27,
    parameter logic [3:0]        NOR_NIB    = 4'h6,
    parameter logic [3:0]        SDR_NIB    = 4'hC
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [2:0]           alias_code,
    input  logic [1:0]           swap_code,
    input  logic [DATA_W-1:0]    cpu_addr,
    output logic [N_REGIONS-1:0] region_sel,
    output logic [DATA_W-1:0]    phys_addr,
    output logic                 dec_err
);
    localparam int         WIN_LG   = 28;
    localparam logic [3:0] NOR2_NIB = NOR_NIB + 4'h1;
    localparam logic [3:0] SDR2_NIB = SDR_NIB + 4'h1;

    function automatic logic in_win(input logic [DATA_W-1:0] a,
                                    input logic [DATA_W-1:0] base, input int lg);
        return (a >> lg) == (base >> lg);
    endfunction

    function automatic logic [DATA_W-1:0] low_bits(input logic [DATA_W-1:0] a, input int lg);
        return a & ((32'h1 << lg) - 32'h1);
    endfunction

    int          al_idx;
    int          al_lg;
    logic [3:0]  nib;
    logic        swapped;

    // Purpose: translate the alias code into a target region and its size.
    always_comb begin
        case (alias_code)
            AL_SYSFL: begin al_idx = RG_SYSFL; al_lg = SYSFL_LG;  end
            AL_NOR:   begin al_idx = RG_NOR;   al_lg = NOR_AL_LG; end
            AL_SRAM:  begin al_idx = RG_SRAM;  al_lg = SRAM_LG;   end
            AL_SDRAM: begin al_idx = RG_SDR1;  al_lg = WIN_LG;    end
            default:  begin al_idx = RG_FLASH; al_lg = FLASH_LG;  end
        endcase
    end

    assign nib     = cpu_addr[31:28];
    assign swapped = (swap_code == SW_SDR);

    // Purpose: priority resolution of alias, on-chip and external windows.
    always_comb begin
        region_sel = '0;
        phys_addr  = '0;
        dec_err    = 1'b0;
        if ((cpu_addr >> al_lg) == '0) begin
            region_sel[al_idx] = 1'b1;
            phys_addr          = cpu_addr;
        end else if (in_win(cpu_addr, FLASH_BASE, FLASH_LG)) begin
            region_sel[RG_FLASH] = 1'b1;
            phys_addr            = low_bits(cpu_addr, FLASH_LG);
        end else if (in_win(cpu_addr, SYSFL_BASE, SYSFL_LG)) begin
            region_sel[RG_SYSFL] = 1'b1;
            phys_addr            = low_bits(cpu_addr, SYSFL_LG);
        end else if (in_win(cpu_addr, SRAM_BASE, SRAM_LG)) begin
            region_sel[RG_SRAM] = 1'b1;
            phys_addr           = low_bits(cpu_addr, SRAM_LG);
        end else if (nib == NOR_NIB) begin
            region_sel[swapped ? RG_SDR1 : RG_NOR] = 1'b1;
            phys_addr = low_bits(cpu_addr, WIN_LG);
        end else if (nib == NOR2_NIB && swapped) begin
            region_sel[RG_SDR2] = 1'b1;
            phys_addr           = low_bits(cpu_addr, WIN_LG);
        end else if (nib == SDR_NIB) begin
            region_sel[swapped ? RG_NOR : RG_SDR1] = 1'b1;
            phys_addr = low_bits(cpu_addr, WIN_LG);
        end else if (nib == SDR2_NIB && !swapped) begin
            region_sel[RG_SDR2] = 1'b1;
            phys_addr           = low_bits(cpu_addr, WIN_LG);
        end else begin
            dec_err = 1'b1;
        end
    end

    p_one_target_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(region_sel) == (dec_err ? 0 : 1));

    p_err_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        dec_err |-> (phys_addr == '0 && region_sel == '0));

    p_swap_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (swap_code == SW_SDR && cpu_addr[31:28] == NOR_NIB) |-> region_sel[RG_SDR1]);

    p_swap_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (swap_code != SW_SDR && cpu_addr[31:28] == NOR2_NIB) |-> dec_err);

    p_resv_alias_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (alias_code > AL_SDRAM && (cpu_addr >> FLASH_LG) == '0) |-> region_sel[RG_FLASH]);
endmodule

// File: rtl/remap_ctrl.sv
// Top level: control word plus address decoder. The decode path is purely
// combinational from cpu_addr and the stored word; writes take one cycle.
module remap_ctrl
    import remap_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  boot_pins,
    input  logic        bus_en,
    input  logic        bus_we,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic [31:0] cpu_addr,
    output logic [5:0]  region_sel,
    output logic [31:0] phys_addr,
    output logic        dec_err
);
    logic [2:0] alias_code;
    logic [1:0] swap_code;

    remap_cfg_reg #(.REG_OFF(8'h00)) u_reg (
        .clk        (clk),
        .rst_n      (rst_n),
        .boot_pins  (boot_pins),
        .bus_en     (bus_en),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .alias_code (alias_code),
        .swap_code  (swap_code)
    );

    remap_addr_dec u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .alias_code (alias_code),
        .swap_code  (swap_code),
        .cpu_addr   (cpu_addr),
        .region_sel (region_sel),
        .phys_addr  (phys_addr),
        .dec_err    (dec_err)
    );
endmodule

// File: tb/remap_ctrl_tb.sv
module remap_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  boot_pins = 2'b10;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] cpu_addr = '0;
    logic [5:0]  region_sel;
    logic [31:0] phys_addr;
    logic        dec_err;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    typedef struct {
        bit          is_read;
        logic [31:0] exp_val;
        logic [5:0]  exp_sel;
        logic        exp_err;
        string       tag;
    } exp_t;

    exp_t q[$];
    event ev_go;

    localparam logic [5:0] S_FL  = 6'b000001;
    localparam logic [5:0] S_SF  = 6'b000010;
    localparam logic [5:0] S_SR  = 6'b000100;
    localparam logic [5:0] S_NOR = 6'b001000;
    localparam logic [5:0] S_SD1 = 6'b010000;
    localparam logic [5:0] S_SD2 = 6'b100000;

    always #4 clk = ~clk;

    remap_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .boot_pins(boot_pins),
        .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cpu_addr(cpu_addr), .region_sel(region_sel),
        .phys_addr(phys_addr), .dec_err(dec_err)
    );

    // Monitor: pops each expected item and compares against the ports.
    initial begin
        forever begin
            exp_t it;
            @(ev_go);
            #2;
            it = q.pop_front();
            n_checks++;
            if (it.is_read) begin
                if (bus_rdata !== it.exp_val) begin
                    n_fail++;
                    $display("FAIL %s rdata actual=%h expected=%h", it.tag, bus_rdata, it.exp_val);
                end
            end else if (region_sel !== it.exp_sel || phys_addr !== it.exp_val || dec_err !== it.exp_err) begin
                n_fail++;
                $display("FAIL %s addr=%h actual sel=%b off=%h err=%b expected sel=%b off=%h err=%b",
                         it.tag, cpu_addr, region_sel, phys_addr, dec_err, it.exp_sel, it.exp_val, it.exp_err);
            end
        end
    end

    task automatic probe(input logic [31:0] a, input logic [5:0] s, input logic [31:0] off,
                         input logic e, input string tag);
        exp_t it;
        @(negedge clk);
        cpu_addr = a;
        it.is_read = 1'b0; it.exp_val = off; it.exp_sel = s; it.exp_err = e; it.tag = tag;
        q.push_back(it);
        -> ev_go;
        #3;
    endtask

    task automatic readback(input logic [7:0] off, input logic [31:0] v, input string tag);
        exp_t it;
        @(negedge clk);
        bus_addr = off;
        it.is_read = 1'b1; it.exp_val = v; it.exp_sel = '0; it.exp_err = 1'b0; it.tag = tag;
        q.push_back(it);
        -> ev_go;
        #3;
    endtask

    task automatic wr(input logic [7:0] off, input logic [31:0] d, input logic en);
        @(negedge clk);
        bus_en = en; bus_we = 1'b1; bus_addr = off; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0; bus_addr = 8'h00;
    endtask

    task automatic do_reset(input logic [1:0] b);
        @(negedge clk);
        rst_n = 1'b0; boot_pins = b;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(8 * 20000);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        do_reset(2'b10);
        readback(8'h00, 32'h0, "R1 strap 10 -> main flash");
        boot_pins = 2'b11;
        repeat (3) @(negedge clk);
        readback(8'h00, 32'h0, "R2 strap change after reset ignored");

        probe(32'h0000_1000, S_FL, 32'h0000_1000, 1'b0, "R5 flash alias");
        probe(32'h0010_0000, 6'b0, 32'h0, 1'b1, "R5 past flash alias size");
        probe(32'h0800_0004, S_FL, 32'h4, 1'b0, "R7 flash native");
        probe(32'h1FFF_7FFC, S_SF, 32'h7FFC, 1'b0, "R7 sysflash top");
        probe(32'h1FFF_8000, 6'b0, 32'h0, 1'b1, "R7 sysflash end");
        probe(32'h2001_FFFF, S_SR, 32'h1FFFF, 1'b0, "R7 sram top");
        probe(32'h6123_4567, S_NOR, 32'h0123_4567, 1'b0, "R8 nor window");
        probe(32'h7000_0000, 6'b0, 32'h0, 1'b1, "R8 gap at 0x7");
        probe(32'hC000_0010, S_SD1, 32'h10, 1'b0, "R8 sdram1");
        probe(32'hD0FF_0000, S_SD2, 32'h00FF_0000, 1'b0, "R8 sdram2");
        probe(32'h4000_0000, 6'b0, 32'h0, 1'b1, "R10 unmapped");

        wr(8'h00, 32'hFFFF_FFFC, 1'b1);
        readback(8'h00, 32'h0000_0C04, "R4 reserved bits masked");
        probe(32'h0FFF_FFF0, S_SD1, 32'h0FFF_FFF0, 1'b0, "R5 sdram alias");
        probe(32'h0800_0000, S_SD1, 32'h0800_0000, 1'b0, "R7 alias overrides flash");
        probe(32'h6000_0000, S_NOR, 32'h0, 1'b0, "R9 reserved swap as none");

        wr(8'h04, 32'h0000_0007, 1'b1);
        readback(8'h00, 32'h0000_0C04, "R4 other offset write ignored");
        readback(8'h04, 32'h0, "R4 other offset reads zero");
        wr(8'h00, 32'h0000_0001, 1'b0);
        readback(8'h00, 32'h0000_0C04, "R3 write without bus_en ignored");

        wr(8'h00, 32'h0000_0402, 1'b1);
        readback(8'h00, 32'h0000_0402, "R3 write nor+swap");
        probe(32'h07FF_FFFF, S_NOR, 32'h07FF_FFFF, 1'b0, "R5 nor alias top");
        probe(32'h0800_0000, S_FL, 32'h0, 1'b0, "R7 flash past nor alias");
        probe(32'h6000_0008, S_SD1, 32'h8, 1'b0, "R9 swapped sdram1");
        probe(32'h7000_0004, S_SD2, 32'h4, 1'b0, "R9 swapped sdram2");
        probe(32'hC123_0000, S_NOR, 32'h0123_0000, 1'b0, "R9 swapped nor");
        probe(32'hD000_0000, 6'b0, 32'h0, 1'b1, "R9 swapped gap");

        wr(8'h00, 32'h0000_0007, 1'b1);
        readback(8'h00, 32'h0000_0007, "R6 reserved code reads back");
        probe(32'h0000_0100, S_FL, 32'h100, 1'b0, "R6 reserved alias is flash");

        wr(8'h00, 32'h0000_0003, 1'b1);
        probe(32'h0001_FFFF, S_SR, 32'h1FFFF, 1'b0, "R5 sram alias top");
        probe(32'h0002_0000, 6'b0, 32'h0, 1'b1, "R5 sram alias end");
        wr(8'h00, 32'h0000_0001, 1'b1);
        probe(32'h0000_7FFF, S_SF, 32'h7FFF, 1'b0, "R5 sysflash alias");

        do_reset(2'b01);
        readback(8'h00, 32'h1, "R1 strap 01 -> system flash");
        do_reset(2'b11);
        readback(8'h00, 32'h3, "R1 strap 11 -> sram");
        do_reset(2'b00);
        readback(8'h00, 32'h0, "R1 strap 00 -> main flash");

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule